// File: doc/BRIEF.md
# Two-Wire Indexed Block Register Slave

This block is a two-wire (SMBus-style) target that lets a host write and read a small bank of byte-wide control registers. Each write transfer carries three parts after the address: a starting index, a byte count, and then that many data bytes. A read transfer sets the index with a short write, issues a repeated start, and then reads. The slave first returns the stored byte count and then the register contents from the chosen index upward. All register contents and the stored count are presented as parallel outputs, so the surrounding logic can use them directly as control bits.

The bus lines are oversampled on a fast system clock through synchronizer chains. START, repeated START and STOP are recognised at any point. The data line is driven only as an open-drain pull-down enable. A two-bit select input chooses one of three 7-bit addresses, so up to three copies can share one segment. The bus may run at up to 100 kHz.

Top module: `smb_regbank_slave`

## Requirements
- R1: With `addr_sel_i` = 0 or 3 the 7-bit address is 0x6E (write byte 0xDC, read byte 0xDD). With 1 it is 0x6C, and with 2 it is 0x6A. An address byte with a different 7-bit address gets no acknowledge (SDA stays high in the ninth clock). The slave then ignores the bus until the next START, so later bytes are not acknowledged and no register changes.
- R2: The slave drives SDA (`sda_drive_low_o` = 1 pulls it low) and changes that drive only while SCL is low.
- R3: A START (SDA falls while SCL is high) restarts address reception at any point, including in the middle of a transfer. A STOP (SDA rises while SCL is high) returns the slave to idle. Both release SDA. Bytes completed before the abort keep their effect, and a partial byte has no effect.
- R4: In a write (address bit 0 = 0), the slave acknowledges the address, the index byte N, the count byte X and each accepted data byte. Data byte k (counting from 0) is stored in register N+k, in ascending order.
- R5: The count byte of a write is stored in the count register (`count_o`) when it is acknowledged. Its reset value is 0.
- R6: Data bytes beyond the X announced by the count byte get no acknowledge and are not stored.
- R7: The index is taken modulo NUM_REGS (8), and auto-increment wraps from the last register to register 0, both on writes and on reads.
- R8: In a read (address bit 0 = 1, after an index write and a repeated START), the slave acknowledges the address. It then sends the stored count, followed by registers N, N+1, and so on, MSB first. It continues while the host acknowledges.
- R9: When the host answers a byte with a not-acknowledge, the slave releases SDA and sends nothing more until the next START.
- R10: After reset all registers and the count are 0x00, and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_drive_low_o | output | 1 | 1 pulls the data line low (open-drain enable) |
| addr_sel_i | input | 2 | Selects one of three target addresses |
| regs_o | output | NUM_REGS*8 | Register k on bits [8k+7:8k] |
| count_o | output | 8 | Stored byte-count register |

## Verification
The bound checker watches, on every cycle, that SDA drive only changes while the synchronized SCL is low, that START and STOP leave SDA released, and that the count register and the register bank change only in the cycle the slave starts an acknowledge. The content and order of what is stored or returned can only be shown by the bench's bus scenarios. These cover the address match for each select value, the index and count sweeps with index wrap, the rejection of bytes beyond the count, mid-transfer aborts, and read-back with a final not-acknowledge.

// File: rtl/smb_rb_pkg.sv
package smb_rb_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_INDEX,
        ST_COUNT,
        ST_WDATA,
        ST_ACK,
        ST_TX,
        ST_RXACK,
        ST_IGNORE
    } rb_state_e;

    typedef logic [7:0] rb_byte_t;

endpackage

// File: rtl/smb_rb_line_sync.sv
module smb_rb_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [SYNC_STAGES-1:0] scl_chain_q;
    logic [SYNC_STAGES-1:0] sda_chain_q;
    logic                   scl_prev_q;
    logic                   sda_prev_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_chain_q <= '1;
                    sda_chain_q <= '1;
                end else begin
                    scl_chain_q <= scl_i;
                    sda_chain_q <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_chain_q <= '1;
                    sda_chain_q <= '1;
                end else begin
                    scl_chain_q <= {scl_chain_q[SYNC_STAGES-2:0], scl_i};
                    sda_chain_q <= {sda_chain_q[SYNC_STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_s;
            sda_prev_q <= sda_s;
        end
    end

    assign scl_s     = scl_chain_q[SYNC_STAGES-1];
    assign sda_s     = sda_chain_q[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~scl_prev_q;
    assign scl_fall  = ~scl_s & scl_prev_q;
    assign start_evt = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    assign stop_evt  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;

endmodule

// File: rtl/smb_rb_regfile.sv
module smb_rb_regfile #(
    parameter int          NUM_REGS = 8,
    parameter logic [7:0]  RST_VAL  = 8'h00,
    localparam int         IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [7:0]            wr_data,
    output logic [NUM_REGS*8-1:0] regs_o
);
    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    regs_o[g*8 +: 8] <= RST_VAL;
                end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                    regs_o[g*8 +: 8] <= wr_data;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/smb_regbank_slave.sv
module smb_regbank_slave
    import smb_rb_pkg::*;
#(
    parameter int         NUM_REGS    = 8,
    parameter logic [6:0] BASE_ADDR   = 7'h6E,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] RST_VAL     = 8'h00
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_drive_low_o,
    input  logic [1:0]            addr_sel_i,
    output logic [NUM_REGS*8-1:0] regs_o,
    output logic [7:0]            count_o
);
    localparam int IDX_W = $clog2(NUM_REGS);

    typedef struct packed {
        rb_state_e        st;
        rb_state_e        nxt;
        logic [3:0]       bit_cnt;
        rb_byte_t         sh;
        logic [IDX_W-1:0] idx;
        rb_byte_t         cnt;
        rb_byte_t         left;
        logic             first;
        logic             drv;
    } core_t;

    core_t d, q;

    logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    rb_byte_t         wr_data;
    rb_byte_t         reg_rd;
    logic [6:0]       my_addr;

    smb_rb_line_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    smb_rb_regfile #(.NUM_REGS(NUM_REGS), .RST_VAL(RST_VAL)) rf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .regs_o  (regs_o)
    );

    always_comb begin
        case (addr_sel_i)
            2'd1:    my_addr = BASE_ADDR - 7'd2;
            2'd2:    my_addr = BASE_ADDR - 7'd4;
            default: my_addr = BASE_ADDR;
        endcase
    end

    assign reg_rd = regs_o[{q.idx, 3'b000} +: 8];

    always_comb begin
        d       = q;
        wr_en   = 1'b0;
        wr_idx  = q.idx;
        wr_data = q.sh;
        if (start_evt) begin
            d.st      = ST_ADDR;
            d.bit_cnt = '0;
            d.drv     = 1'b0;
        end else if (stop_evt) begin
            d.st      = ST_IDLE;
            d.bit_cnt = '0;
            d.drv     = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR, ST_INDEX, ST_COUNT, ST_WDATA: begin
                    if (scl_rise) begin
                        d.sh      = {q.sh[6:0], sda_s};
                        d.bit_cnt = q.bit_cnt + 4'd1;
                    end else if (scl_fall && q.bit_cnt == 4'd8) begin
                        d.bit_cnt = '0;
                        d.st      = ST_ACK;
                        d.drv     = 1'b1;
                        case (q.st)
                            ST_ADDR: begin
                                if (q.sh[7:1] != my_addr) begin
                                    d.st  = ST_IGNORE;
                                    d.drv = 1'b0;
                                end else if (q.sh[0]) begin
                                    d.nxt   = ST_TX;
                                    d.first = 1'b1;
                                end else begin
                                    d.nxt = ST_INDEX;
                                end
                            end
                            ST_INDEX: begin
                                d.idx = q.sh[IDX_W-1:0];
                                d.nxt = ST_COUNT;
                            end
                            ST_COUNT: begin
                                d.cnt  = q.sh;
                                d.left = q.sh;
                                d.nxt  = ST_WDATA;
                            end
                            default: begin
                                if (q.left == 8'd0) begin
                                    d.st  = ST_IGNORE;
                                    d.drv = 1'b0;
                                end else begin
                                    wr_en  = 1'b1;
                                    d.idx  = q.idx + 1'b1;
                                    d.left = q.left - 8'd1;
                                    d.nxt  = ST_WDATA;
                                end
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.bit_cnt = '0;
                        d.st      = q.nxt;
                        d.drv     = 1'b0;
                        if (q.nxt == ST_TX) begin
                            d.sh    = q.first ? q.cnt : reg_rd;
                            d.idx   = q.first ? q.idx : q.idx + 1'b1;
                            d.first = 1'b0;
                            d.drv   = ~d.sh[7];
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        d.bit_cnt = q.bit_cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (q.bit_cnt == 4'd8) begin
                            d.bit_cnt = '0;
                            d.drv     = 1'b0;
                            d.st      = ST_RXACK;
                        end else begin
                            d.sh  = {q.sh[6:0], 1'b0};
                            d.drv = ~q.sh[6];
                        end
                    end
                end
                ST_RXACK: begin
                    if (scl_rise) begin
                        if (sda_s) begin
                            d.st = ST_IGNORE;
                        end else begin
                            d.st  = ST_ACK;
                            d.nxt = ST_TX;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st      <= ST_IDLE;
            q.nxt     <= ST_IDLE;
            q.bit_cnt <= '0;
            q.sh      <= '0;
            q.idx     <= '0;
            q.cnt     <= '0;
            q.left    <= '0;
            q.first   <= 1'b0;
            q.drv     <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sda_drive_low_o = q.drv;
    assign count_o         = q.cnt;

endmodule

// File: rtl/smb_rb_checker.sv
module smb_rb_checker #(
    parameter int RW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_s,
    input logic          start_evt,
    input logic          stop_evt,
    input logic          sda_drive_low_o,
    input logic [7:0]    count_o,
    input logic [RW-1:0] regs_o
);
    // R2: drive toggles only while the synchronized clock line is low
    a_r2_drive_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_drive_low_o != $past(sda_drive_low_o)) |->
            (!scl_s || $past(start_evt) || $past(stop_evt)));

    // R3: a START leaves the data line released
    a_r3_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> !sda_drive_low_o);

    // R3: a STOP leaves the data line released
    a_r3_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_drive_low_o);

    // R5: the count register moves only when an acknowledge begins
    a_r5_count_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o != $past(count_o)) |-> $rose(sda_drive_low_o));

    // R4: register contents move only when an acknowledge begins
    a_r4_regs_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_o != $past(regs_o)) |-> $rose(sda_drive_low_o));

endmodule

bind smb_regbank_slave smb_rb_checker #(.RW(NUM_REGS*8)) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .scl_s           (scl_s),
    .start_evt       (start_evt),
    .stop_evt        (stop_evt),
    .sda_drive_low_o (sda_drive_low_o),
    .count_o         (count_o),
    .regs_o          (regs_o)
);

// File: tb/smb_regbank_slave_tb.sv
module smb_regbank_slave_tb_top;
    localparam int NR = 8;
    localparam int Q  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scl_drv = 1'b1;
    logic          host_sda = 1'b1;
    logic [1:0]    addr_sel = 2'd0;
    logic          drv;
    logic          sda_line;
    logic [NR*8-1:0] regs;
    logic [7:0]    cnt;

    int n_tests = 0;
    int n_fail  = 0;
    int r2_viol = 0;
    logic [7:0] exp_regs [NR];
    logic [7:0] exp_cnt;
    logic       prev_drv = 1'b0;

    assign sda_line = host_sda & ~drv;

    always #4 clk = ~clk;

    smb_regbank_slave dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .scl_i           (scl_drv),
        .sda_i           (sda_line),
        .sda_drive_low_o (drv),
        .addr_sel_i      (addr_sel),
        .regs_o          (regs),
        .count_o         (cnt)
    );

    always @(negedge clk) begin
        if (drv != prev_drv && scl_drv) r2_viol++;
        prev_drv <= drv;
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic waitq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        scl_drv = 1'b0; waitq();
        host_sda = 1'b1; waitq();
        scl_drv = 1'b1; waitq();
        host_sda = 1'b0; waitq();
        scl_drv = 1'b0; waitq();
    endtask

    task automatic bus_stop();
        scl_drv = 1'b0; waitq();
        host_sda = 1'b0; waitq();
        scl_drv = 1'b1; waitq();
        host_sda = 1'b1; waitq();
    endtask

    task automatic clock_bit(input bit b, output bit seen);
        scl_drv = 1'b0; host_sda = b; waitq(); waitq();
        scl_drv = 1'b1; waitq();
        seen = sda_line; waitq();
        scl_drv = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v, output bit acked);
        bit s;
        for (int i = 7; i >= 0; i--) clock_bit(v[i], s);
        clock_bit(1'b1, s);
        acked = (s == 1'b0);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] v);
        bit s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            v[i] = s;
        end
        clock_bit(~give_ack, s);
    endtask

    function automatic logic [6:0] sel_addr(input logic [1:0] sel);
        case (sel)
            2'd1:    return 7'h6C;
            2'd2:    return 7'h6A;
            default: return 7'h6E;
        endcase
    endfunction

    function automatic logic [7:0] pat(input int n, input int k, input int x);
        return 8'((n * 37 + k * 11 + x * 5 + 3) & 8'hFF);
    endfunction

    task automatic check_bank(input string req);
        for (int r = 0; r < NR; r++)
            check(regs[r*8 +: 8] == exp_regs[r], req, regs[r*8 +: 8], exp_regs[r]);
    endtask

    task automatic do_write(input logic [7:0] n, input int x, input int extra);
        bit a;
        bus_start();
        send_byte({sel_addr(addr_sel), 1'b0}, a);
        check(a, "R4 addr ack", a, 1);
        send_byte(n, a);
        check(a, "R4 index ack", a, 1);
        send_byte(8'(x), a);
        check(a, "R4 count ack", a, 1);
        exp_cnt = 8'(x);
        for (int k = 0; k < x + extra; k++) begin
            send_byte(pat(n, k, x), a);
            if (k < x) begin
                check(a, "R4 data ack", a, 1);
                exp_regs[(int'(n) + k) % NR] = pat(n, k, x);
            end else begin
                check(!a, "R6 excess byte nack", a, 0);
            end
        end
        bus_stop();
        check_bank("R4 R7 bank contents");
        check(cnt == exp_cnt, "R5 count register", cnt, exp_cnt);
    endtask

    task automatic do_read(input logic [7:0] n, input int nb);
        bit a;
        bit s;
        logic [7:0] v;
        bus_start();
        send_byte({sel_addr(addr_sel), 1'b0}, a);
        send_byte(n, a);
        bus_start();
        send_byte({sel_addr(addr_sel), 1'b1}, a);
        check(a, "R8 read addr ack", a, 1);
        recv_byte(1'b1, v);
        check(v == exp_cnt, "R8 count first", v, exp_cnt);
        for (int k = 0; k < nb; k++) begin
            recv_byte(k != nb - 1, v);
            check(v == exp_regs[(int'(n) + k) % NR], "R8 R7 read data", v,
                  exp_regs[(int'(n) + k) % NR]);
        end
        clock_bit(1'b1, s);
        check(s == 1'b1, "R9 released after nack", s, 1);
        bus_stop();
    endtask

    initial begin
        bit a;
        bit s;
        for (int r = 0; r < NR; r++) exp_regs[r] = 8'h00;
        exp_cnt = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R10 reset state
        check(regs == '0, "R10 regs reset", 0, 0);
        check(cnt == 8'h00, "R10 count reset", cnt, 0);
        check(drv == 1'b0, "R10 sda released", drv, 0);

        // R1 address sweep per select value
        for (int sel = 0; sel < 4; sel++) begin
            addr_sel = 2'(sel);
            for (int c = 0; c < 4; c++) begin
                logic [6:0] cand;
                cand = (c == 0) ? 7'h6E : (c == 1) ? 7'h6C : (c == 2) ? 7'h6A : 7'h12;
                bus_start();
                send_byte({cand, 1'b0}, a);
                check(a == (cand == sel_addr(2'(sel))), "R1 address match", a,
                      cand == sel_addr(2'(sel)));
                if (!a) begin
                    send_byte(8'h01, a);
                    check(!a, "R1 ignored after mismatch", a, 0);
                    send_byte(8'h01, a);
                    send_byte(8'h5A, a);
                end
                bus_stop();
            end
        end
        check_bank("R1 no change from foreign address");

        // R4 R5 R7 write sweep
        addr_sel = 2'd1;
        for (int n = 0; n < NR; n++) begin
            do_write(8'(n), 1, 0);
            do_write(8'(n), 3, 0);
            do_write(8'(n), NR, 0);
        end

        // R6 bytes beyond the count
        do_write(8'd2, 2, 2);

        // R7 index beyond the bank
        do_write(8'h0D, 2, 0);

        // R8 R9 reads with wrap
        addr_sel = 2'd2;
        for (int n = 0; n < NR; n++) do_read(8'(n), NR);
        do_read(8'h0B, 3);

        // R3 repeated START in the middle of a write
        addr_sel = 2'd0;
        bus_start();
        send_byte(8'hDC, a);
        send_byte(8'h01, a);
        send_byte(8'h03, a);
        send_byte(8'hA5, a);
        exp_regs[1] = 8'hA5;
        exp_cnt = 8'h03;
        bus_start();
        check(drv == 1'b0, "R3 start releases", drv, 0);
        send_byte(8'hDC, a);
        check(a, "R3 restart addr ack", a, 1);
        send_byte(8'h05, a);
        send_byte(8'h01, a);
        send_byte(8'h3C, a);
        exp_regs[5] = 8'h3C;
        exp_cnt = 8'h01;
        bus_stop();
        check_bank("R3 after restart");
        check(cnt == exp_cnt, "R3 R5 count after restart", cnt, exp_cnt);

        // R3 STOP in the middle of a data byte
        bus_start();
        send_byte(8'hDC, a);
        send_byte(8'h06, a);
        send_byte(8'h02, a);
        exp_cnt = 8'h02;
        clock_bit(1'b0, s);
        clock_bit(1'b1, s);
        clock_bit(1'b1, s);
        bus_stop();
        check(drv == 1'b0, "R3 stop releases", drv, 0);
        check_bank("R3 partial byte dropped");
        do_read(8'h05, 2);

        check(r2_viol == 0, "R2 drive changed while SCL high", r2_viol, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule